// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of one line of a snooping write-back cache. The line can be in one of five states: Modified, Owned, Exclusive, Shared and Invalid. Each cycle the controller looks at one processor access, one snooped bus transaction and one fill completion. From these it works out the line's next state and the bus command to issue. It also raises a flag when this cache must drive the line's data onto the bus, raises a write-back request when dirty data must go to memory, and drives its contribution to a wired-OR shared signal.

Tag comparison, data storage and bus arbitration are handled elsewhere. The surrounding cache supplies the hit indications and carries out the commands. A processor miss evicts the current contents, issues a bus read or read-exclusive and leaves the line waiting for a fill. When the fill returns, the line becomes Exclusive if no other cache asserted the shared signal and Shared if one did. A fill for a write makes the line Modified. A Modified line that another cache reads becomes Owned: it keeps its dirty data and serves later readers, and it is written back only when it is replaced.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 (Invalid), `fill_pending` is 0 and `bus_req`, `supply_data`, `writeback_req` and `shared_out` are all 0. The state codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Owned and 4 Modified. A reset taken while a fill is pending clears the pending fill.
- R2: A processor read that misses (`cpu_hit` low, or any access while the line is Invalid) drives `bus_req` = 1 (read) in that cycle, and `next_state` is Invalid. When the fill returns (`fill_valid`), the line becomes Exclusive (2) if `fill_shared` is 0 and Shared (1) if it is 1. The bus codes are 0 none, 1 read, 2 read-exclusive and 3 invalidate.
- R3: A processor write that misses drives `bus_req` = 2 (read-exclusive). The matching fill makes the line Modified (4).
- R4: A miss from Modified or Owned raises `writeback_req` in the same cycle. A miss from Exclusive or Shared drops the line without a write-back.
- R5: A processor write hit on an Exclusive line moves it to Modified with `bus_req` = 0.
- R6: A processor write hit on a Shared or Owned line drives `bus_req` = 3 (invalidate) and moves the line to Modified.
- R7: A read hit on any valid line, and a write hit on a Modified line, leave the state unchanged and issue no bus command.
- R8: A snooped read (`snoop_op` = 1) that hits moves Modified to Owned, keeps Owned as Owned and moves Exclusive to Shared. Modified and Owned assert `supply_data`. No write-back is raised.
- R9: A snooped read-exclusive (`snoop_op` = 2) that hits moves any valid state to Invalid. Modified and Owned assert `supply_data`.
- R10: A snooped invalidate (`snoop_op` = 3) that hits moves any valid state to Invalid. Only a Modified line raises `writeback_req`.
- R11: `shared_out` is 1 exactly when `snoop_valid` and `snoop_hit` are high, `snoop_op` is non-zero and the line is valid. A snoop to an Invalid line or one that misses the tag changes nothing.
- R12: In any cycle with `snoop_valid` high, the processor request has no effect: no processor bus command is issued and only the snoop acts on the state.
- R13: While a fill is pending (`fill_pending` = 1), the line reads Invalid and processor requests are ignored (`bus_req` = 0). A `fill_valid` with no fill pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access this cycle |
| cpu_write | input | 1 | Access is a write |
| cpu_hit | input | 1 | Tag matched for the processor access |
| snoop_valid | input | 1 | Snooped bus transaction this cycle |
| snoop_op | input | 2 | Snooped command: 1 read, 2 read-exclusive, 3 invalidate |
| snoop_hit | input | 1 | Tag matched for the snooped address |
| fill_valid | input | 1 | Requested block has arrived |
| fill_shared | input | 1 | Sampled wired-OR shared signal for the fill |
| line_state | output | 3 | Current state code |
| next_state | output | 3 | State taken at the next edge |
| bus_req | output | 2 | Bus command to issue this cycle |
| supply_data | output | 1 | Drive the line's data onto the bus |
| writeback_req | output | 1 | Write dirty data back to memory |
| shared_out | output | 1 | This cache's contribution to the shared signal |
| fill_pending | output | 1 | A fill is outstanding |

## Verification
A table drives each of the five states into every processor access kind (read or write, hit or miss) and every snoop command. This separates silent upgrades from invalidating upgrades, and dirty evictions from clean drops. Snoop rows that carry a miss, target an Invalid line or coincide with a processor write show that the snoop wins and that the processor request has no effect. Directed sequences return fills with the shared signal both low and high, which separates the Exclusive outcome from the Shared one. They also issue processor requests and stray fills while a fill is or is not pending, and reset the block in the middle of a fill.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_INV  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_RD   = 2'd1,
        PEND_WR   = 2'd2
    } pend_e;

    typedef struct packed {
        line_st_e nxt;
        bus_op_e  bus;
        logic     supply;
        logic     wb;
        logic     shared;
        pend_e    pend;
    } action_t;

    function automatic logic is_valid(line_st_e s);
        return s != ST_I;
    endfunction

    function automatic logic is_dirty(line_st_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic action_t hold_action(line_st_e s);
        action_t a;
        a.nxt    = s;
        a.bus    = BUS_NONE;
        a.supply = 1'b0;
        a.wb     = 1'b0;
        a.shared = 1'b0;
        a.pend   = PEND_NONE;
        return a;
    endfunction

endpackage

// File: rtl/moesi_cpu_side.sv
module moesi_cpu_side
    import moesi_pkg::*;
(
    input  line_st_e state,
    input  logic     cpu_valid,
    input  logic     cpu_write,
    input  logic     cpu_hit,
    output logic     act_en,
    output action_t  act
);
    logic miss;

    always_comb begin
        miss   = !cpu_hit || !is_valid(state);
        act    = hold_action(state);
        act_en = cpu_valid;
        if (cpu_valid) begin
            if (miss) begin
                // evict current contents and fetch the requested block
                act.nxt  = ST_I;
                act.bus  = cpu_write ? BUS_RDX : BUS_RD;
                act.wb   = is_dirty(state);
                act.pend = cpu_write ? PEND_WR : PEND_RD;
            end else if (cpu_write) begin
                case (state)
                    ST_E: act.nxt = ST_M;
                    ST_S, ST_O: begin
                        act.nxt = ST_M;
                        act.bus = BUS_INV;
                    end
                    default: act.nxt = state;
                endcase
            end
        end
    end
endmodule

// File: rtl/moesi_snoop_side.sv
module moesi_snoop_side
    import moesi_pkg::*;
(
    input  line_st_e   state,
    input  logic       snoop_valid,
    input  logic [1:0] snoop_op,
    input  logic       snoop_hit,
    output logic       act_en,
    output action_t    act
);
    bus_op_e op;

    always_comb begin
        op     = bus_op_e'(snoop_op);
        act    = hold_action(state);
        act_en = snoop_valid && snoop_hit && is_valid(state) && (op != BUS_NONE);
        if (act_en) begin
            act.shared = 1'b1;
            case (op)
                BUS_RD: begin
                    case (state)
                        ST_M: begin
                            act.nxt    = ST_O;
                            act.supply = 1'b1;
                        end
                        ST_O: act.supply = 1'b1;
                        ST_E: act.nxt = ST_S;
                        default: act.nxt = state;
                    endcase
                end
                BUS_RDX: begin
                    act.nxt    = ST_I;
                    act.supply = is_dirty(state);
                end
                BUS_INV: begin
                    act.nxt = ST_I;
                    act.wb  = (state == ST_M);
                end
                default: act.nxt = state;
            endcase
        end
    end
endmodule

// File: rtl/moesi_fill_tracker.sv
module moesi_fill_tracker
    import moesi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pend_e   start,
    input  logic    fill_valid,
    input  logic    fill_shared,
    output logic    pending,
    output logic    fill_en,
    output action_t fill_act
);
    pend_e pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= PEND_NONE;
        else if (fill_en)
            pend_q <= PEND_NONE;
        else if (start != PEND_NONE)
            pend_q <= start;
    end

    always_comb begin
        pending  = (pend_q != PEND_NONE);
        fill_en  = fill_valid && pending;
        fill_act = hold_action(ST_I);
        if (pend_q == PEND_WR)
            fill_act.nxt = ST_M;
        else if (pend_q == PEND_RD)
            fill_act.nxt = fill_shared ? ST_S : ST_E;
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_valid,
    input  logic       cpu_write,
    input  logic       cpu_hit,
    input  logic       snoop_valid,
    input  logic [1:0] snoop_op,
    input  logic       snoop_hit,
    input  logic       fill_valid,
    input  logic       fill_shared,
    output logic [2:0] line_state,
    output logic [2:0] next_state,
    output logic [1:0] bus_req,
    output logic       supply_data,
    output logic       writeback_req,
    output logic       shared_out,
    output logic       fill_pending
);
    line_st_e state_q;
    action_t  cpu_act, snp_act, fill_act, sel;
    logic     cpu_en, snp_en, fill_en, pending;

    moesi_cpu_side u_cpu (
        .state     (state_q),
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_hit   (cpu_hit),
        .act_en    (cpu_en),
        .act       (cpu_act)
    );

    moesi_snoop_side u_snp (
        .state       (state_q),
        .snoop_valid (snoop_valid),
        .snoop_op    (snoop_op),
        .snoop_hit   (snoop_hit),
        .act_en      (snp_en),
        .act         (snp_act)
    );

    moesi_fill_tracker u_fill (
        .clk         (clk),
        .rst         (rst),
        .start       (sel.pend),
        .fill_valid  (fill_valid),
        .fill_shared (fill_shared),
        .pending     (pending),
        .fill_en     (fill_en),
        .fill_act    (fill_act)
    );

    // snoop first, then fill completion, then processor when the bus side is quiet
    always_comb begin
        if (snp_en)
            sel = snp_act;
        else if (fill_en)
            sel = fill_act;
        else if (cpu_en && !pending && !snoop_valid)
            sel = cpu_act;
        else
            sel = hold_action(state_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_I;
        else
            state_q <= sel.nxt;
    end

    assign line_state    = state_q;
    assign next_state    = sel.nxt;
    assign bus_req       = sel.bus;
    assign supply_data   = sel.supply;
    assign writeback_req = sel.wb;
    assign shared_out    = sel.shared;
    assign fill_pending  = pending;
endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_valid,
    input logic       cpu_write,
    input logic       cpu_hit,
    input logic       snoop_valid,
    input logic [1:0] snoop_op,
    input logic       snoop_hit,
    input logic       fill_valid,
    input logic [2:0] line_state,
    input logic [1:0] bus_req,
    input logic       supply_data,
    input logic       writeback_req,
    input logic       shared_out,
    input logic       fill_pending
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (line_state == 3'd0) && !fill_pending);

    p_fill_lands_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_pending) |=>
            (line_state == 3'd1 || line_state == 3'd2 || line_state == 3'd4));

    p_clean_no_writeback_r4: assert property (@(posedge clk) disable iff (rst)
        (line_state == 3'd0 || line_state == 3'd1 || line_state == 3'd2) |-> !writeback_req);

    p_exclusive_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_write && cpu_hit && line_state == 3'd2 && !snoop_valid && !fill_pending)
            |-> bus_req == 2'd0 ##1 line_state == 3'd4);

    p_owned_supplies_r8: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_hit && snoop_op == 2'd1 && line_state == 3'd3) |-> supply_data);

    p_invalidate_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_hit && snoop_op == 2'd3) |=> line_state == 3'd0);

    p_shared_needs_hit_r11: assert property (@(posedge clk) disable iff (rst)
        shared_out |-> (snoop_valid && snoop_hit && line_state != 3'd0));

    p_snoop_blocks_cpu_r12: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |-> bus_req == 2'd0);

    p_pending_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        fill_pending |-> (bus_req == 2'd0) && (line_state == 3'd0));

    p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
        line_state <= 3'd4);
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_hit       (cpu_hit),
    .snoop_valid   (snoop_valid),
    .snoop_op      (snoop_op),
    .snoop_hit     (snoop_hit),
    .fill_valid    (fill_valid),
    .line_state    (line_state),
    .bus_req       (bus_req),
    .supply_data   (supply_data),
    .writeback_req (writeback_req),
    .shared_out    (shared_out),
    .fill_pending  (fill_pending)
);

// File: tb/moesi_line_ctrl_test.sv
module moesi_line_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_valid = 1'b0, cpu_write = 1'b0, cpu_hit = 1'b0;
    logic       snoop_valid = 1'b0, snoop_hit = 1'b0;
    logic [1:0] snoop_op = 2'd0;
    logic       fill_valid = 1'b0, fill_shared = 1'b0;
    logic [2:0] line_state, next_state;
    logic [1:0] bus_req;
    logic       supply_data, writeback_req, shared_out, fill_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    moesi_line_ctrl uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit),
        .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_hit(snoop_hit),
        .fill_valid(fill_valid), .fill_shared(fill_shared),
        .line_state(line_state), .next_state(next_state), .bus_req(bus_req),
        .supply_data(supply_data), .writeback_req(writeback_req),
        .shared_out(shared_out), .fill_pending(fill_pending)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] st;
        logic       cv, cw, ch, sv;
        logic [1:0] so;
        logic       sh;
        logic [2:0] en;
        logic [1:0] eb;
        logic       es, ew, eh;
    } vec_t;

    localparam int NV = 29;
    // start state, cpu valid/write/hit, snoop valid/op/hit, expected next/bus/supply/wb/shared
    localparam vec_t VECS [NV] = '{
        '{4'd2,  3'd0, 1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd1, 1'b0,1'b0,1'b0}, // R2
        '{4'd3,  3'd0, 1'b1,1'b1,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd2, 1'b0,1'b0,1'b0}, // R3
        '{4'd3,  3'd0, 1'b1,1'b1,1'b1, 1'b0,2'd0,1'b0, 3'd0,2'd2, 1'b0,1'b0,1'b0}, // R3
        '{4'd4,  3'd2, 1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd1, 1'b0,1'b0,1'b0}, // R4
        '{4'd4,  3'd1, 1'b1,1'b1,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd2, 1'b0,1'b0,1'b0}, // R4
        '{4'd4,  3'd4, 1'b1,1'b0,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd1, 1'b0,1'b1,1'b0}, // R4
        '{4'd4,  3'd3, 1'b1,1'b1,1'b0, 1'b0,2'd0,1'b0, 3'd0,2'd2, 1'b0,1'b1,1'b0}, // R4
        '{4'd5,  3'd2, 1'b1,1'b1,1'b1, 1'b0,2'd0,1'b0, 3'd4,2'd0, 1'b0,1'b0,1'b0}, // R5
        '{4'd6,  3'd1, 1'b1,1'b1,1'b1, 1'b0,2'd0,1'b0, 3'd4,2'd3, 1'b0,1'b0,1'b0}, // R6
        '{4'd6,  3'd3, 1'b1,1'b1,1'b1, 1'b0,2'd0,1'b0, 3'd4,2'd3, 1'b0,1'b0,1'b0}, // R6
        '{4'd7,  3'd4, 1'b1,1'b1,1'b1, 1'b0,2'd0,1'b0, 3'd4,2'd0, 1'b0,1'b0,1'b0}, // R7
        '{4'd7,  3'd2, 1'b1,1'b0,1'b1, 1'b0,2'd0,1'b0, 3'd2,2'd0, 1'b0,1'b0,1'b0}, // R7
        '{4'd7,  3'd3, 1'b1,1'b0,1'b1, 1'b0,2'd0,1'b0, 3'd3,2'd0, 1'b0,1'b0,1'b0}, // R7
        '{4'd8,  3'd4, 1'b0,1'b0,1'b0, 1'b1,2'd1,1'b1, 3'd3,2'd0, 1'b1,1'b0,1'b1}, // R8
        '{4'd8,  3'd3, 1'b0,1'b0,1'b0, 1'b1,2'd1,1'b1, 3'd3,2'd0, 1'b1,1'b0,1'b1}, // R8
        '{4'd8,  3'd2, 1'b0,1'b0,1'b0, 1'b1,2'd1,1'b1, 3'd1,2'd0, 1'b0,1'b0,1'b1}, // R8
        '{4'd8,  3'd1, 1'b0,1'b0,1'b0, 1'b1,2'd1,1'b1, 3'd1,2'd0, 1'b0,1'b0,1'b1}, // R8
        '{4'd9,  3'd4, 1'b0,1'b0,1'b0, 1'b1,2'd2,1'b1, 3'd0,2'd0, 1'b1,1'b0,1'b1}, // R9
        '{4'd9,  3'd3, 1'b0,1'b0,1'b0, 1'b1,2'd2,1'b1, 3'd0,2'd0, 1'b1,1'b0,1'b1}, // R9
        '{4'd9,  3'd2, 1'b0,1'b0,1'b0, 1'b1,2'd2,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b1}, // R9
        '{4'd9,  3'd1, 1'b0,1'b0,1'b0, 1'b1,2'd2,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b1}, // R9
        '{4'd10, 3'd4, 1'b0,1'b0,1'b0, 1'b1,2'd3,1'b1, 3'd0,2'd0, 1'b0,1'b1,1'b1}, // R10
        '{4'd10, 3'd3, 1'b0,1'b0,1'b0, 1'b1,2'd3,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b1}, // R10
        '{4'd10, 3'd2, 1'b0,1'b0,1'b0, 1'b1,2'd3,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b1}, // R10
        '{4'd11, 3'd0, 1'b0,1'b0,1'b0, 1'b1,2'd1,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b0}, // R11
        '{4'd11, 3'd4, 1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0, 3'd4,2'd0, 1'b0,1'b0,1'b0}, // R11
        '{4'd12, 3'd4, 1'b1,1'b1,1'b1, 1'b1,2'd1,1'b1, 3'd3,2'd0, 1'b1,1'b0,1'b1}, // R12
        '{4'd12, 3'd1, 1'b1,1'b1,1'b1, 1'b1,2'd2,1'b1, 3'd0,2'd0, 1'b0,1'b0,1'b1}, // R12
        '{4'd12, 3'd2, 1'b1,1'b1,1'b1, 1'b1,2'd0,1'b0, 3'd2,2'd0, 1'b0,1'b0,1'b0}  // R12
    };

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet;
        cpu_valid = 1'b0; cpu_write = 1'b0; cpu_hit = 1'b0;
        snoop_valid = 1'b0; snoop_op = 2'd0; snoop_hit = 1'b0;
        fill_valid = 1'b0; fill_shared = 1'b0;
    endtask

    // inputs change 1 ns after a rising edge; outputs are read at the falling edge
    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        quiet();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic goto_state(logic [2:0] st);
        do_reset();
        if (st != 3'd0) begin
            cpu_valid = 1'b1;
            cpu_write = (st == 3'd4 || st == 3'd3);
            tick();
            quiet();
            fill_valid  = 1'b1;
            fill_shared = (st == 3'd1);
            tick();
            quiet();
            if (st == 3'd3) begin
                snoop_valid = 1'b1; snoop_op = 2'd1; snoop_hit = 1'b1;
                tick();
                quiet();
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", "line_state", line_state, 0);
        check("R1", "fill_pending", fill_pending, 0);
        check("R1", "bus_req", bus_req, 0);
        check("R1", "supply_data", supply_data, 0);
        check("R1", "writeback_req", writeback_req, 0);
        check("R1", "shared_out", shared_out, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            goto_state(VECS[i].st);
            cpu_valid = VECS[i].cv; cpu_write = VECS[i].cw; cpu_hit = VECS[i].ch;
            snoop_valid = VECS[i].sv; snoop_op = VECS[i].so; snoop_hit = VECS[i].sh;
            @(negedge clk);
            check(tag, "start state", line_state, int'(VECS[i].st));
            check(tag, "next_state", next_state, int'(VECS[i].en));
            check(tag, "bus_req", bus_req, int'(VECS[i].eb));
            check(tag, "supply_data", supply_data, int'(VECS[i].es));
            check(tag, "writeback_req", writeback_req, int'(VECS[i].ew));
            check(tag, "shared_out", shared_out, int'(VECS[i].eh));
            tick();
            quiet();
            check(tag, "line_state after", line_state, int'(VECS[i].en));
        end

        // R2 and R13: read miss, pending window, fill without sharers
        do_reset();
        cpu_valid = 1'b1;
        tick();
        quiet();
        @(negedge clk);
        check("R13", "fill_pending", fill_pending, 1);
        check("R13", "line_state pending", line_state, 0);
        cpu_valid = 1'b1; cpu_write = 1'b1;
        #1;
        check("R13", "bus_req during pending", bus_req, 0);
        tick();
        quiet();
        fill_valid = 1'b1; fill_shared = 1'b0;
        tick();
        quiet();
        check("R2", "fill unshared state", line_state, 2);
        check("R2", "pending cleared", fill_pending, 0);

        // R13: stray fill with nothing pending
        fill_valid = 1'b1; fill_shared = 1'b1;
        tick();
        quiet();
        check("R13", "stray fill state", line_state, 2);

        // R2: fill with a sharer
        do_reset();
        cpu_valid = 1'b1;
        tick();
        quiet();
        fill_valid = 1'b1; fill_shared = 1'b1;
        tick();
        quiet();
        check("R2", "fill shared state", line_state, 1);

        // R3: write fill ignores shared signal
        do_reset();
        cpu_valid = 1'b1; cpu_write = 1'b1;
        tick();
        quiet();
        fill_valid = 1'b1; fill_shared = 1'b1;
        tick();
        quiet();
        check("R3", "write fill state", line_state, 4);

        // R1: reset in the middle of a fill
        do_reset();
        cpu_valid = 1'b1;
        tick();
        quiet();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1", "pending after reset", fill_pending, 0);
        fill_valid = 1'b1;
        tick();
        quiet();
        check("R1", "fill after reset ignored", line_state, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule